// File: doc/BRIEF.md
# Down-Counting Timer Channel with Two Match Points

This block is one channel of a general-purpose timer. It holds a reload value and two match thresholds. Once enabled, it counts down from the reload value to zero, one step per selected tick, and then starts again from the reload value. The tick comes from one of two single-cycle strobes. One is a fixed 1 MHz strobe and the other is derived from the bus clock. Both strobes are produced outside the block.

An interrupt event occurs when the count steps onto an effective match value, and again at zero when the zero condition holds. Each event inverts the `irq` line and sets a sticky `status` flag. The surrounding register decoder drives the write strobes and the data bus, and reads back `count_rd`.

The control sequence is a four-state machine:
- **ST_OFF**: the channel is disabled. The count is frozen and the read port shows the reload value.
- **ST_ARM**: the channel is enabled and waits for its first tick, which loads the reload value.
- **ST_RUN**: the channel is counting.
- **ST_HOLD**: the channel is enabled, but the reload value is zero, so the count is parked at zero.

The transitions are:
- OFF→ARM when `en` rises.
- OFF→RUN or ARM→RUN on a count write.
- ARM→RUN on the first tick when the reload value is nonzero.
- ARM→HOLD on the first tick when the reload value is zero.
- RUN→HOLD when a wrap finds a zero reload value.
- HOLD→RUN on a count write or on a nonzero reload write.
- Any state →OFF when `en` falls.

Top module: `dmt_channel`

## Requirements
- R1: With `ext_sel`=1 only `tick_ext` advances the count. With `ext_sel`=0 only `tick_bus` advances it. Strobes on the unselected input have no effect.
- R2: After `en` rises, `count_rd` reads the reload value until the first selected tick. That tick loads the reload value. Each later tick decrements the count by one. A tick at count zero loads the reload value again.
- R3: A match value equal to or greater than the reload value is treated as zero. It therefore never causes an event at a nonzero count.
- R4: An event occurs on the tick that moves the count onto a nonzero effective match value. Two equal match values produce a single event.
- R5: When a tick moves the count onto zero, an event occurs if `ovf_irq_en`=1 or if either stored match value is zero. Otherwise no event occurs at zero.
- R6: Each event inverts `irq` and sets `status`. `status` stays at 1 until reset.
- R7: While `en`=0, `count_rd` equals the reload value, ticks cause no event, and count writes are ignored.
- R8: A count write while enabled makes `count_rd` equal the written value one cycle later. The write causes no event, and it wins over a tick in the same cycle.
- R9: If the first tick finds a zero reload value, `count_rd` stays 0 and ticks do nothing. A later nonzero reload write restarts counting from that value.
- R10: A reload write while counting leaves the live count alone. The new value is used from the next wrap onward.
- R11: Reset clears the reload value, both match values, `irq` and `status`, so `count_rd` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Channel enable |
| ext_sel | input | 1 | 1 selects the 1 MHz tick, 0 selects the bus tick |
| ovf_irq_en | input | 1 | Enables the event at zero |
| tick_ext | input | 1 | 1 MHz tick strobe |
| tick_bus | input | 1 | Bus-clock tick strobe |
| wr_count | input | 1 | Write strobe for the current count |
| wr_reload | input | 1 | Write strobe for the reload value |
| wr_match | input | NUM_MATCH | Write strobes for the match values, one bit per threshold |
| wr_data | input | CNT_W | Write data |
| count_rd | output | CNT_W | Readable count: the live count, or the reload value while disabled or arming |
| irq | output | 1 | Interrupt line, inverted on each event |
| status | output | 1 | Sticky event flag |

## Verification
The hardest situations to reach are the parked state and the restart from it. Reaching them needs three steps in order:
1. Program a zero reload value while the channel is disabled.
2. Enable the channel.
3. Deliver one tick, which moves the state machine into ST_HOLD.

Only after that does a nonzero reload write show whether counting restarts from the written value. The stimulus also sets the zero-event enable during the parked period. This shows that parked ticks raise no event even though the zero condition is true. A second case that is hard to reach is a count write arriving in the same cycle as a tick. The bench drives both strobes in one cycle and checks that the written value is what appears next.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_HOLD = 2'd3
    } chan_state_t;
endpackage

// File: rtl/dmt_tick_sel.sv
module dmt_tick_sel (
    input  logic ext_sel,
    input  logic tick_ext,
    input  logic tick_bus,
    output logic tick
);
    always_comb begin
        tick = ext_sel ? tick_ext : tick_bus;
    end
endmodule

// File: rtl/dmt_regs.sv
module dmt_regs #(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_reload,
    input  logic [NUM_MATCH-1:0]                wr_match,
    input  logic [CNT_W-1:0]                    wr_data,
    output logic [CNT_W-1:0]                    reload_q,
    output logic [NUM_MATCH-1:0][CNT_W-1:0]     match_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr_reload) begin
            reload_q <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_match
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                match_q[g] <= '0;
            end else if (wr_match[g]) begin
                match_q[g] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/dmt_fsm_ctr.sv
module dmt_fsm_ctr
    import dmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             wr_count,
    input  logic             wr_reload,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] reload_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             step,
    output logic [CNT_W-1:0] count_rd
);
    chan_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             reload_zero;
    logic             wdata_nonzero;

    always_comb begin
        reload_zero   = (reload_q == '0);
        wdata_nonzero = (wr_data != '0);
    end

    // next-state and next-count decision
    always_comb begin
        state_d = state_q;
        cnt_nxt = cnt_q;
        step    = 1'b0;
        if (!en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (wr_count) begin
                        cnt_nxt = wr_data;
                        state_d = ST_RUN;
                    end else begin
                        state_d = ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (wr_count) begin
                        cnt_nxt = wr_data;
                        state_d = ST_RUN;
                    end else if (tick) begin
                        cnt_nxt = reload_q;
                        state_d = reload_zero ? ST_HOLD : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (wr_count) begin
                        cnt_nxt = wr_data;
                    end else if (wr_reload && reload_zero && wdata_nonzero) begin
                        cnt_nxt = wr_data;
                    end else if (tick) begin
                        if (cnt_q == '0) begin
                            cnt_nxt = reload_q;
                            if (reload_zero) begin
                                state_d = ST_HOLD;
                            end
                        end else begin
                            cnt_nxt = cnt_q - 1'b1;
                            step    = 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (wr_count) begin
                        cnt_nxt = wr_data;
                        state_d = ST_RUN;
                    end else if (wr_reload && wdata_nonzero) begin
                        cnt_nxt = wr_data;
                        state_d = ST_RUN;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_nxt;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_OFF, ST_ARM: count_rd = reload_q;
            default:        count_rd = cnt_q;
        endcase
    end
endmodule

// File: rtl/dmt_event.sv
module dmt_event #(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            step,
    input  logic                            ovf_irq_en,
    input  logic [CNT_W-1:0]                cnt_nxt,
    input  logic [CNT_W-1:0]                reload_q,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0] match_q,
    output logic                            irq,
    output logic                            status
);
    logic [NUM_MATCH-1:0] hit_m;
    logic [NUM_MATCH-1:0] raw_zero;
    logic                 at_zero;
    logic                 hit;

    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_cmp
        logic [CNT_W-1:0] eff;
        always_comb begin
            eff         = (match_q[g] < reload_q) ? match_q[g] : '0;
            hit_m[g]    = (eff != '0) && (eff == cnt_nxt);
            raw_zero[g] = (match_q[g] == '0);
        end
    end

    always_comb begin
        at_zero = (cnt_nxt == '0);
        hit     = step && (at_zero ? (ovf_irq_en || (|raw_zero)) : (|hit_m));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq    <= 1'b0;
            status <= 1'b0;
        end else if (hit) begin
            irq    <= ~irq;
            status <= 1'b1;
        end
    end
endmodule

// File: rtl/dmt_channel.sv
module dmt_channel #(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 ext_sel,
    input  logic                 ovf_irq_en,
    input  logic                 tick_ext,
    input  logic                 tick_bus,
    input  logic                 wr_count,
    input  logic                 wr_reload,
    input  logic [NUM_MATCH-1:0] wr_match,
    input  logic [CNT_W-1:0]     wr_data,
    output logic [CNT_W-1:0]     count_rd,
    output logic                 irq,
    output logic                 status
);
    logic                            tick;
    logic [CNT_W-1:0]                reload_q;
    logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;
    logic [CNT_W-1:0]                cnt_nxt;
    logic                            step;

    dmt_tick_sel u_tick (
        .ext_sel  (ext_sel),
        .tick_ext (tick_ext),
        .tick_bus (tick_bus),
        .tick     (tick)
    );

    dmt_regs #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_reload (wr_reload),
        .wr_match  (wr_match),
        .wr_data   (wr_data),
        .reload_q  (reload_q),
        .match_q   (match_q)
    );

    dmt_fsm_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .wr_count  (wr_count),
        .wr_reload (wr_reload),
        .wr_data   (wr_data),
        .reload_q  (reload_q),
        .cnt_nxt   (cnt_nxt),
        .step      (step),
        .count_rd  (count_rd)
    );

    dmt_event #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .ovf_irq_en (ovf_irq_en),
        .cnt_nxt    (cnt_nxt),
        .reload_q   (reload_q),
        .match_q    (match_q),
        .irq        (irq),
        .status     (status)
    );
endmodule

// File: rtl/dmt_channel_chk.sv
module dmt_channel_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             ext_sel,
    input logic             tick_ext,
    input logic             tick_bus,
    input logic             wr_count,
    input logic             wr_reload,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count_rd,
    input logic             irq,
    input logic             status
);
    logic sel_tick;
    always_comb sel_tick = ext_sel ? tick_ext : tick_bus;

    AST_EVENT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq) |-> ($past(en) && $past(sel_tick) && !$past(wr_count))); // R7

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status) |-> status); // R6

    AST_IRQ_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq) |-> status); // R6

    AST_OFF_READS_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!en) && $past(wr_reload)) |-> (count_rd == $past(wr_data))); // R7

    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_count) && $past(en) && en) |-> (count_rd == $past(wr_data))); // R8
endmodule

bind dmt_channel dmt_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ext_sel   (ext_sel),
    .tick_ext  (tick_ext),
    .tick_bus  (tick_bus),
    .wr_count  (wr_count),
    .wr_reload (wr_reload),
    .wr_data   (wr_data),
    .count_rd  (count_rd),
    .irq       (irq),
    .status    (status)
);

// File: tb/sim_dmt_channel.sv
module sim_dmt_channel;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0, ext_sel = 1'b0, ovf_irq_en = 1'b0;
    logic          tick_ext = 1'b0, tick_bus = 1'b0;
    logic          wr_count = 1'b0, wr_reload = 1'b0;
    logic [1:0]    wr_match = 2'b00;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  count_rd;
    logic          irq, status;

    int n_tests = 0, n_fail = 0, toggles = 0;
    logic irq_prev = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dmt_channel u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .ext_sel(ext_sel), .ovf_irq_en(ovf_irq_en),
        .tick_ext(tick_ext), .tick_bus(tick_bus), .wr_count(wr_count),
        .wr_reload(wr_reload), .wr_match(wr_match), .wr_data(wr_data),
        .count_rd(count_rd), .irq(irq), .status(status)
    );

    always @(posedge clk) begin
        #2;
        if (irq !== irq_prev) toggles++;
        irq_prev = irq;
    end

    // rows: reload, match0, match1, ovf, ext, ticks after load, final count, events
    localparam int NR = 7;
    localparam int T_R  [NR] = '{10, 10,  8, 8, 6,  5, 4};
    localparam int T_M0 [NR] = '{ 6,  6,  8, 0, 4,  2, 3};
    localparam int T_M1 [NR] = '{ 3,  3, 20, 5, 4,  7, 1};
    localparam int T_OV [NR] = '{ 0,  1,  0, 0, 0,  1, 0};
    localparam int T_EX [NR] = '{ 0,  1,  0, 1, 0,  1, 1};
    localparam int T_N  [NR] = '{10, 12,  8, 8, 6, 13, 4};
    localparam int T_C  [NR] = '{ 0,  9,  0, 0, 0,  4, 0};
    localparam int T_EV [NR] = '{ 2,  3,  0, 2, 1,  4, 2};

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // selected strobe, then a strobe on the other source that must be ignored (R1)
    task automatic pulse();
        if (ext_sel) tick_ext = 1'b1; else tick_bus = 1'b1;
        cyc();
        tick_ext = 1'b0; tick_bus = 1'b0;
        if (ext_sel) tick_bus = 1'b1; else tick_ext = 1'b1;
        cyc();
        tick_ext = 1'b0; tick_bus = 1'b0;
    endtask

    task automatic wr(input int kind, input int data);
        wr_data = data;
        case (kind)
            0: wr_count = 1'b1;
            1: wr_reload = 1'b1;
            2: wr_match = 2'b01;
            default: wr_match = 2'b10;
        endcase
        cyc();
        wr_count = 1'b0; wr_reload = 1'b0; wr_match = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        cyc(); cyc();
        chk("R11 reset count", count_rd, 0);
        chk("R11 reset irq", irq, 0);
        chk("R11 reset status", status, 0);
        rst_n = 1'b1;
        cyc();

        for (int r = 0; r < NR; r++) begin
            en = 1'b0; cyc();
            wr(1, T_R[r]); wr(2, T_M0[r]); wr(3, T_M1[r]);
            ovf_irq_en = T_OV[r][0]; ext_sel = T_EX[r][0];
            chk("R7 disabled reads reload", count_rd, T_R[r]);
            base = toggles;
            en = 1'b1; cyc();
            chk("R2 armed reads reload", count_rd, T_R[r]);
            pulse();
            chk("R2 first tick loads", count_rd, T_R[r]);
            for (int k = 0; k < T_N[r]; k++) pulse();
            chk("R1 R2 count after ticks", count_rd, T_C[r]);
            chk("R3 R4 R5 event count", toggles - base, T_EV[r]);
            if (T_EV[r] > 0) chk("R6 status set", status, 1);
        end

        // R8: count write, no event, precedence over tick
        en = 1'b0; cyc();
        wr(1, 10); wr(2, 6); wr(3, 3);
        ovf_irq_en = 1'b1; ext_sel = 1'b0;
        en = 1'b1; cyc();
        pulse(); pulse(); pulse();
        chk("R2 count 8", count_rd, 8);
        base = toggles;
        wr(0, 6);
        chk("R8 count write value", count_rd, 6);
        chk("R8 count write no event", toggles - base, 0);
        pulse();
        chk("R8 decrement after write", count_rd, 5);
        tick_bus = 1'b1; wr(0, 9); tick_bus = 1'b0;
        chk("R8 write beats tick", count_rd, 9);

        // R10: reload write during counting
        wr(1, 4);
        chk("R10 live count kept", count_rd, 9);
        for (int k = 0; k < 10; k++) pulse();
        chk("R10 new reload at wrap", count_rd, 4);

        // R7: disabled behaviour
        en = 1'b0; cyc();
        base = toggles;
        chk("R7 disabled reads reload", count_rd, 4);
        for (int k = 0; k < 12; k++) pulse();
        chk("R7 no events while disabled", toggles - base, 0);
        wr(0, 2);
        chk("R7 count write ignored read", count_rd, 4);
        en = 1'b1; cyc();
        pulse();
        chk("R7 count write ignored after enable", count_rd, 4);

        // R9: zero reload parks, nonzero reload restarts
        en = 1'b0; cyc();
        wr(1, 0);
        en = 1'b1; cyc();
        pulse();
        chk("R9 parked count", count_rd, 0);
        base = toggles;
        pulse(); pulse(); pulse();
        chk("R9 parked stays zero", count_rd, 0);
        chk("R9 parked no events", toggles - base, 0);
        wr(1, 7);
        chk("R9 restart value", count_rd, 7);
        pulse();
        chk("R9 counting after restart", count_rd, 6);

        // R11: reset mid-run clears everything
        rst_n = 1'b0; en = 1'b0; ovf_irq_en = 1'b0; cyc();
        chk("R11 count after reset", count_rd, 0);
        chk("R11 irq after reset", irq, 0);
        chk("R11 status after reset", status, 0);
        rst_n = 1'b1; cyc();
        wr(1, 5);
        base = toggles;
        en = 1'b1; cyc();
        pulse();
        for (int k = 0; k < 5; k++) pulse();
        chk("R11 matches cleared: one zero event", toggles - base, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule